// File: doc/BRIEF.md
# Program/Erase Status Reporter

This block stands beside the array of a word-wide nonvolatile memory and decides what a host read returns while an internal program or erase is in flight. A decoder, which is not part of this block, issues a one-cycle start pulse with the operation type and the word being programmed once the last write of a command sequence has been taken. From the next clock on the block reports busy and alters two bits of every read word, so software can poll for completion.

The duration of each operation comes from a down-counter. Its reload value depends on the operation type, and each type has its own parameter: word program, sector or block erase, and chip erase. The defaults are the worst-case times at a 125 MHz clock: 40 µs, 50 ms and 200 ms. On a program, the polling bit returns the inverse of the matching bit of the word being written. On any erase, the polling bit reads 0. The toggle bit changes value on each read strobe and does not change with time. Once the counter expires, reads return the array word unchanged. A start pulse that arrives while an operation is running is dropped.

Top module: `pe_status_rpt`

## Requirements
- R1: While reset is asserted and right after it, `busy_o` is 0 and `rdata_o` equals `arr_i`.
- R2: A start with `op_i` = 2'b00 (program) taken while idle raises `busy_o` on the next clock, and `busy_o` stays high for exactly `PROG_CYCLES` cycles.
- R3: A start with `op_i` = 2'b01 (sector erase) or 2'b10 (block erase) taken while idle keeps `busy_o` high for exactly `ERASE_CYCLES` cycles.
- R4: A start with `op_i` = 2'b11 (chip erase) taken while idle keeps `busy_o` high for exactly `CHIP_CYCLES` cycles.
- R5: While a program is busy, bit `POLL_BIT` (default 7) of `rdata_o` is the inverse of bit `POLL_BIT` of `wdata_i` as sampled with the start. Later changes of `wdata_i` have no effect on it.
- R6: While any erase is busy, bit `POLL_BIT` of `rdata_o` reads 0.
- R7: While busy, bit `TOG_BIT` (default 6) of `rdata_o` reads 0 until the first read of the operation. Each clock edge with `rd_i` high inverts it, and it holds its value on edges without a read.
- R8: A start pulse while `busy_o` is high is ignored. The running operation keeps its duration, its polling bit and its toggle state.
- R9: While `busy_o` is low, `rdata_o` equals `arr_i` on every bit. Reads made while idle have no effect on the toggle value of the next operation.
- R10: While busy, every bit of `rdata_o` other than `POLL_BIT` and `TOG_BIT` equals the same bit of `arr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: internal operation begins |
| op_i | input | 2 | Operation type: 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| wdata_i | input | DW | Word being programmed, sampled with the start |
| rd_i | input | 1 | Read strobe, one per host read |
| arr_i | input | DW | Word currently read from the array |
| busy_o | output | 1 | Internal operation running |
| rdata_o | output | DW | Read word with status bits substituted while busy |

## Verification
The assertions check on every cycle that busy rises after an accepted start and survives a start that is dropped. They check that the idle read path is transparent and that the untouched bits pass through while busy. They also check that the toggle bit moves exactly on read edges, that an erase forces the polling bit low, and that every busy window has the length its operation type sets, using a cycle counter in the checker. Two properties rely on the bench's scenarios instead. The first is that the programmed polling bit tracks the word sampled at the start even when `wdata_i` later changes. The second is that idle reads leave no trace on the next operation's toggle sequence. The bench shows both by running random operation types and read patterns against a cycle model.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
   typedef enum logic [1:0] {
      OP_PROG = 2'b00,
      OP_SECT = 2'b01,
      OP_BLK  = 2'b10,
      OP_CHIP = 2'b11
   } pe_op_e;
endpackage

// File: rtl/pe_status_timer.sv
module pe_status_timer
   import pe_status_pkg::*;
#(
   parameter int unsigned PROG_CYCLES  = 5000,
   parameter int unsigned ERASE_CYCLES = 6250000,
   parameter int unsigned CHIP_CYCLES  = 25000000,
   parameter int unsigned CNT_W        = 25
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [1:0] op_i,
   output logic       accept_o,
   output logic       busy_o
);
   localparam logic [CNT_W-1:0] LD_PROG  = CNT_W'(PROG_CYCLES);
   localparam logic [CNT_W-1:0] LD_ERASE = CNT_W'(ERASE_CYCLES);
   localparam logic [CNT_W-1:0] LD_CHIP  = CNT_W'(CHIP_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;
   logic             busy_q;

   assign accept_o = start_i & ~busy_q;
   assign busy_o   = busy_q;

   always_comb begin
      case (pe_op_e'(op_i))
         OP_PROG: load_val = LD_PROG;
         OP_CHIP: load_val = LD_CHIP;
         default: load_val = LD_ERASE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (accept_o) begin
         busy_q <= 1'b1;
         cnt_q  <= load_val;
      end else if (busy_q) begin
         if (cnt_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
         end
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/pe_status_flags.sv
module pe_status_flags
   import pe_status_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept_i,
   input  logic [1:0] op_i,
   input  logic       wbit_i,
   input  logic       busy_i,
   input  logic       rd_i,
   output logic       poll_o,
   output logic       tog_o
);
   logic poll_q;
   logic tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_q <= 1'b0;
         tog_q  <= 1'b0;
      end else if (accept_i) begin
         poll_q <= (pe_op_e'(op_i) == OP_PROG) ? ~wbit_i : 1'b0;
         tog_q  <= 1'b0;
      end else if (busy_i && rd_i) begin
         tog_q <= ~tog_q;
      end
   end

   assign poll_o = poll_q;
   assign tog_o  = tog_q;
endmodule

// File: rtl/pe_status_mux.sv
module pe_status_mux #(
   parameter int unsigned DW       = 16,
   parameter int unsigned POLL_BIT = 7,
   parameter int unsigned TOG_BIT  = 6
) (
   input  logic          busy_i,
   input  logic          poll_i,
   input  logic          tog_i,
   input  logic [DW-1:0] arr_i,
   output logic [DW-1:0] rdata_o
);
   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (b == POLL_BIT) begin : g_poll
         assign rdata_o[b] = busy_i ? poll_i : arr_i[b];
      end else if (b == TOG_BIT) begin : g_tog
         assign rdata_o[b] = busy_i ? tog_i : arr_i[b];
      end else begin : g_pass
         assign rdata_o[b] = arr_i[b];
      end
   end
endmodule

// File: rtl/pe_status_rpt.sv
module pe_status_rpt #(
   parameter int unsigned DW           = 16,
   parameter int unsigned POLL_BIT     = 7,
   parameter int unsigned TOG_BIT      = 6,
   parameter int unsigned PROG_CYCLES  = 5000,
   parameter int unsigned ERASE_CYCLES = 6250000,
   parameter int unsigned CHIP_CYCLES  = 25000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    op_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          rd_i,
   input  logic [DW-1:0] arr_i,
   output logic          busy_o,
   output logic [DW-1:0] rdata_o
);
   localparam int unsigned MAX_A = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int unsigned MAX_C = (MAX_A > CHIP_CYCLES) ? MAX_A : CHIP_CYCLES;
   localparam int unsigned CNT_W = $clog2(MAX_C + 1);

   if (DW < 2) begin : g_bad_dw
      $error("pe_status_rpt: DW must be at least 2");
   end
   if (POLL_BIT >= DW || TOG_BIT >= DW || POLL_BIT == TOG_BIT) begin : g_bad_bits
      $error("pe_status_rpt: status bit positions invalid");
   end
   if (PROG_CYCLES == 0 || ERASE_CYCLES == 0 || CHIP_CYCLES == 0) begin : g_bad_cnt
      $error("pe_status_rpt: cycle counts must be nonzero");
   end

   logic accept;
   logic busy;
   logic poll;
   logic tog;

   pe_status_timer #(
      .PROG_CYCLES (PROG_CYCLES),
      .ERASE_CYCLES(ERASE_CYCLES),
      .CHIP_CYCLES (CHIP_CYCLES),
      .CNT_W       (CNT_W)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .op_i    (op_i),
      .accept_o(accept),
      .busy_o  (busy)
   );

   pe_status_flags flags_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept_i(accept),
      .op_i    (op_i),
      .wbit_i  (wdata_i[POLL_BIT]),
      .busy_i  (busy),
      .rd_i    (rd_i),
      .poll_o  (poll),
      .tog_o   (tog)
   );

   pe_status_mux #(
      .DW      (DW),
      .POLL_BIT(POLL_BIT),
      .TOG_BIT (TOG_BIT)
   ) mux_i (
      .busy_i (busy),
      .poll_i (poll),
      .tog_i  (tog),
      .arr_i  (arr_i),
      .rdata_o(rdata_o)
   );

   assign busy_o = busy;
endmodule

// File: rtl/pe_status_rpt_chk.sv
module pe_status_rpt_chk #(
   parameter int unsigned DW           = 16,
   parameter int unsigned POLL_BIT     = 7,
   parameter int unsigned TOG_BIT      = 6,
   parameter int unsigned PROG_CYCLES  = 5000,
   parameter int unsigned ERASE_CYCLES = 6250000,
   parameter int unsigned CHIP_CYCLES  = 25000000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic [1:0]    op_i,
   input logic [DW-1:0] wdata_i,
   input logic          rd_i,
   input logic [DW-1:0] arr_i,
   input logic          busy_o,
   input logic [DW-1:0] rdata_o
);
   logic [DW-1:0] keep_mask;
   always_comb begin
      keep_mask = '1;
      keep_mask[POLL_BIT] = 1'b0;
      keep_mask[TOG_BIT]  = 1'b0;
   end

   function automatic int unsigned len_of(input logic [1:0] op);
      case (op)
         2'b00:   len_of = PROG_CYCLES;
         2'b11:   len_of = CHIP_CYCLES;
         default: len_of = ERASE_CYCLES;
      endcase
   endfunction

   int unsigned run_q;
   int unsigned exp_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 0;
         exp_q <= 0;
      end else if (start_i && !busy_o) begin
         run_q <= 0;
         exp_q <= len_of(op_i);
      end else if (busy_o) begin
         run_q <= run_q + 1;
      end
   end

   // R2
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R2, R3, R4
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_q == exp_q));

   // R6
   erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_i != 2'b00) |=> (rdata_o[POLL_BIT] == 1'b0));

   // R7
   tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && rd_i) |=> (!busy_o || rdata_o[TOG_BIT] != $past(rdata_o[TOG_BIT])));

   // R7
   tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !rd_i) |=> (!busy_o || $stable(rdata_o[TOG_BIT])));

   // R8
   start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o && run_q + 1 < exp_q) |=> busy_o);

   // R9
   idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (rdata_o == arr_i));

   // R10
   busy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> ((rdata_o & keep_mask) == (arr_i & keep_mask)));
endmodule

bind pe_status_rpt pe_status_rpt_chk #(
   .DW          (DW),
   .POLL_BIT    (POLL_BIT),
   .TOG_BIT     (TOG_BIT),
   .PROG_CYCLES (PROG_CYCLES),
   .ERASE_CYCLES(ERASE_CYCLES),
   .CHIP_CYCLES (CHIP_CYCLES)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .op_i   (op_i),
   .wdata_i(wdata_i),
   .rd_i   (rd_i),
   .arr_i  (arr_i),
   .busy_o (busy_o),
   .rdata_o(rdata_o)
);

// File: tb/pe_status_rpt_tb_top.sv
module pe_status_rpt_tb_top;
   localparam int DW = 16;
   localparam int PB = 7;
   localparam int TB = 6;
   localparam int NP = 6;
   localparam int NE = 11;
   localparam int NC = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    op_i = '0;
   logic [DW-1:0] wdata_i = '0;
   logic          rd_i = 1'b0;
   logic [DW-1:0] arr_i = '0;
   logic          busy_o;
   logic [DW-1:0] rdata_o;

   int n_chk = 0;
   int n_fail = 0;

   // model state
   logic   m_busy = 1'b0;
   int     m_rem = 0;
   logic   m_tog = 1'b0;
   logic   m_poll = 1'b0;
   logic   m_prog = 1'b0;
   string  m_tag = "R2";
   logic   m_drop = 1'b0;

   always #4 clk = ~clk;

   pe_status_rpt #(
      .DW(DW), .POLL_BIT(PB), .TOG_BIT(TB),
      .PROG_CYCLES(NP), .ERASE_CYCLES(NE), .CHIP_CYCLES(NC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .wdata_i(wdata_i), .rd_i(rd_i), .arr_i(arr_i),
      .busy_o(busy_o), .rdata_o(rdata_o)
   );

   function automatic int len_of(input logic [1:0] op);
      if (op == 2'b00) return NP;
      if (op == 2'b11) return NC;
      return NE;
   endfunction

   function automatic string dur_tag(input logic [1:0] op);
      if (op == 2'b00) return "R2";
      if (op == 2'b11) return "R4";
      return "R3";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: called at negedge, returns at next negedge
   task automatic step(input logic st, input logic [1:0] op, input logic [DW-1:0] wd,
                       input logic rd, input logic [DW-1:0] arr);
      logic [DW-1:0] exp_w;
      start_i = st; op_i = op; wdata_i = wd; rd_i = rd; arr_i = arr;
      #1;
      chk(m_drop ? "R8" : m_tag, {31'd0, busy_o}, {31'd0, m_busy});
      if (!m_busy) begin
         chk("R9", {16'd0, rdata_o}, {16'd0, arr});
      end else begin
         exp_w = arr;
         chk(m_prog ? "R5" : "R6", {31'd0, rdata_o[PB]}, {31'd0, m_poll});
         chk("R7", {31'd0, rdata_o[TB]}, {31'd0, m_tog});
         exp_w[PB] = rdata_o[PB];
         exp_w[TB] = rdata_o[TB];
         chk("R10", {16'd0, rdata_o}, {16'd0, exp_w});
      end
      @(posedge clk);
      if (st && !m_busy) begin
         m_busy = 1'b1;
         m_rem  = len_of(op);
         m_tog  = 1'b0;
         m_prog = (op == 2'b00);
         m_poll = (op == 2'b00) ? ~wd[PB] : 1'b0;
         m_tag  = dur_tag(op);
         m_drop = 1'b0;
      end else if (m_busy) begin
         if (st) m_drop = 1'b1;
         if (rd) m_tog = ~m_tog;
         m_rem--;
         if (m_rem == 0) m_busy = 1'b0;
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      arr_i = 16'hA5C3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1", {31'd0, busy_o}, 32'd0);
      chk("R1", {16'd0, rdata_o}, {16'd0, arr_i});
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {31'd0, busy_o}, 32'd0);

      // R9 idle reads, then R2/R5/R7 program with data bit set, no reads for a while
      for (int i = 0; i < 3; i++) step(1'b0, 2'b00, '0, 1'b1, 16'h1234 + 16'(i));
      step(1'b1, 2'b00, 16'h0080, 1'b0, 16'hFFFF);
      for (int i = 0; i < NP + 2; i++) step(1'b0, 2'b00, 16'h0000, (i % 3) == 1, 16'h00FF);
      // R3 sector erase with reads every cycle, R8 start while busy
      step(1'b1, 2'b01, 16'hFFFF, 1'b0, 16'hFFFF);
      for (int i = 0; i < NE + 2; i++) step(i == 2 || i == 5, 2'b11, 16'h0000, 1'b1, 16'hFF3F);
      // R3 block erase, R4 chip erase
      step(1'b1, 2'b10, 16'h0000, 1'b1, 16'h0000);
      for (int i = 0; i < NE + 1; i++) step(1'b0, 2'b00, 16'h0000, 1'b0, 16'h8000);
      step(1'b1, 2'b11, 16'h0000, 1'b0, 16'h0040);
      for (int i = 0; i < NC + 1; i++) step(i == NC - 2, 2'b00, 16'h0000, i[0], 16'hFFFF);
      // R2 with programmed bit clear, start on the last busy cycle dropped (R8)
      step(1'b1, 2'b00, 16'h0000, 1'b1, 16'h0000);
      for (int i = 0; i < NP + 1; i++) step(i == NP - 1, 2'b01, 16'h0080, 1'b0, 16'h0000);

      // random operations
      for (int k = 0; k < 60; k++) begin
         logic [1:0] op;
         op = 2'($urandom_range(0, 3));
         step(1'b1, op, 16'($urandom), 1'($urandom), 16'($urandom));
         for (int i = 0; i < len_of(op) + 1; i++)
            step(($urandom_range(0, 9) == 0), 2'($urandom), 16'($urandom),
                 1'($urandom), 16'($urandom));
         for (int i = 0; i < int'($urandom_range(0, 3)); i++)
            step(1'b0, 2'b00, 16'($urandom), 1'($urandom), 16'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule